// File: doc/BRIEF.md
# Trail Trace Identifier Capture Buffer

This block collects a 16-byte trail access point identifier that a far-end transmitter sends one byte per frame. An upstream frame processor supplies the trail trace byte from each received frame together with a one-cycle valid strobe. A byte with its top bit set marks the start of a message: it is stored in slot 0. The bytes from later frames fill slots 1 through 15 in turn. Once the buffer is full, further ordinary bytes are dropped until the next marker arrives.

Each marker sets a sticky change flag in an interrupt status register. An interrupt line follows that flag, gated by a software-writable enable bit. A simple microprocessor port reads back the sixteen slots, the status register and the enable register. Reading the status register clears the change flag. The block does not check the CRC-7 field carried in the marker byte; software validates it against the stored bytes.

Top module: `trail_id_capture`

## Requirements
- R1: After reset every slot reads 0x00, the status and enable registers read 0x00, and `irq` is low.
- R2: A valid byte with bit 7 = 1 is written to slot 0. This happens wherever the previous message stood, even part-way through it.
- R3: After a marker, each later valid byte with bit 7 = 0 goes into the next slot in order, slot 1 first and slot 15 last. Cycles with `rx_valid` low change nothing.
- R4: Valid bytes with bit 7 = 0 are discarded and leave every slot unchanged in two cases: before the first marker after reset, and after slot 15 has been filled but before the next marker.
- R5: A read (`rd_en` high) of address 0x1C+i, for i = 0..15, returns slot i on `rd_data` in the following cycle. A read of any address that is not mapped returns 0x00.
- R6: The status register at 0x15 has the change flag in bit 6, which is set by every marker. All of its other bits read 0.
- R7: A read of 0x15 returns the flag as it stood before the read and then clears it.
- R8: If a marker and a status read fall in the same cycle, the read returns the old value and the flag ends up set.
- R9: Writing address 0x11 (`cfg_wr` high) loads the enable from bit 6 of `cfg_data`. Reading 0x11 returns the enable in bit 6. `irq` is high exactly when both the flag and the enable are set, and it stays high until the flag is cleared by a read or the enable is cleared.
- R10: Slot 0 keeps all eight bits of the marker byte exactly as received, whatever its low seven bits hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | Trail trace byte strobe, one cycle per frame |
| rx_byte | input | 8 | Trail trace byte from the current frame |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 8 | Register read address |
| rd_data | output | 8 | Read data, valid the cycle after `rd_en` |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 8 | Register write address |
| cfg_data | input | 8 | Register write data |
| irq | output | 1 | Trail trace change interrupt |

## Verification
The hardest case to reach from the ports is a marker that lands in the same cycle as a status read. If the set does not win there, the event is lost. The stimulus aims a status read at a marker both in a directed case and across the random phase. The random phase uses many reads of 0x15 and a high marker rate, so the two meet many times. Directed sequences also cover a marker arriving in the middle of a message, overflow past slot 15, bytes sent before any marker, and a marker with all low bits set. The random phase then mixes gaps between strobes with reads of every address.

// File: rtl/trail_id_pkg.sv
package trail_id_pkg;
    localparam int SLOTS_DEF     = 16;
    localparam logic [7:0] SLOT_BASE_DEF = 8'h1C;
    localparam logic [7:0] STAT_ADDR_DEF = 8'h15;
    localparam logic [7:0] ENAB_ADDR_DEF = 8'h11;
    localparam int FLAG_BIT      = 6;

    typedef struct packed {
        logic       valid;
        logic [7:0] data;
    } tt_byte_t;

    function automatic logic is_marker(input logic [7:0] b);
        return b[7];
    endfunction

    function automatic logic [7:0] flag_to_reg(input logic f);
        logic [7:0] r;
        r = 8'h00;
        r[FLAG_BIT] = f;
        return r;
    endfunction
endpackage

// File: rtl/trail_id_seq.sv
module trail_id_seq
    import trail_id_pkg::*;
#(
    parameter int DEPTH = SLOTS_DEF,
    localparam int IW = $clog2(DEPTH),
    localparam int PW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  tt_byte_t      rx,
    output logic          wr_en,
    output logic [IW-1:0] wr_idx,
    output logic [7:0]    wr_data,
    output logic          msg_start
);
    logic [PW-1:0] ptr;          // next slot; DEPTH means idle (full or unarmed)
    logic          room;

    assign room      = ptr < PW'(DEPTH);
    assign msg_start = rx.valid && is_marker(rx.data);
    assign wr_en     = msg_start || (rx.valid && room);
    assign wr_idx    = msg_start ? '0 : ptr[IW-1:0];
    assign wr_data   = rx.data;

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr <= PW'(DEPTH);
        end else if (msg_start) begin
            ptr <= PW'(1);
        end else if (rx.valid && room) begin
            ptr <= ptr + PW'(1);
        end
    end

    p_ptr_bound_r4: assert property (@(posedge clk) disable iff (rst)
        ptr <= PW'(DEPTH));
    p_restart_r2: assert property (@(posedge clk) disable iff (rst)
        msg_start |=> ptr == PW'(1));
    p_idle_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (!room && rx.valid && !is_marker(rx.data)) |=> ptr == PW'(DEPTH));
endmodule

// File: rtl/trail_id_store.sv
module trail_id_store #(
    parameter int DEPTH = 16,
    localparam int IW = $clog2(DEPTH)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_en,
    input  logic [IW-1:0]         wr_idx,
    input  logic [7:0]            wr_data,
    output logic [DEPTH-1:0][7:0] slots
);
    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                slots[g] <= 8'h00;
            end else if (wr_en && wr_idx == IW'(g)) begin
                slots[g] <= wr_data;
            end
        end
    end

    p_write_lands_r3: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> slots[$past(wr_idx)] == $past(wr_data));
    p_quiet_stable_r3: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(slots));
endmodule

// File: rtl/trail_id_status.sv
module trail_id_status (
    input  logic clk,
    input  logic rst,
    input  logic set_evt,
    input  logic clr_evt,
    input  logic en_wr,
    input  logic en_val,
    output logic flag,
    output logic enable,
    output logic irq
);
    always_ff @(posedge clk) begin
        if (rst) begin
            flag <= 1'b0;
        end else if (set_evt) begin
            flag <= 1'b1;
        end else if (clr_evt) begin
            flag <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            enable <= 1'b0;
        end else if (en_wr) begin
            enable <= en_val;
        end
    end

    assign irq = flag & enable;

    p_flag_set_r6: assert property (@(posedge clk) disable iff (rst)
        set_evt |=> flag);
    p_set_wins_r8: assert property (@(posedge clk) disable iff (rst)
        (set_evt && clr_evt) |=> flag);
    p_clear_r7: assert property (@(posedge clk) disable iff (rst)
        (clr_evt && !set_evt) |=> !flag);
    p_irq_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (irq && !clr_evt && !en_wr) |=> irq);
endmodule

// File: rtl/trail_id_capture.sv
module trail_id_capture
    import trail_id_pkg::*;
#(
    parameter int         DEPTH     = SLOTS_DEF,
    parameter logic [7:0] SLOT_BASE = SLOT_BASE_DEF,
    parameter logic [7:0] STAT_ADDR = STAT_ADDR_DEF,
    parameter logic [7:0] ENAB_ADDR = ENAB_ADDR_DEF
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       rx_valid,
    input  logic [7:0] rx_byte,
    input  logic       rd_en,
    input  logic [7:0] rd_addr,
    output logic [7:0] rd_data,
    input  logic       cfg_wr,
    input  logic [7:0] cfg_addr,
    input  logic [7:0] cfg_data,
    output logic       irq
);
    localparam int IW = $clog2(DEPTH);

    tt_byte_t              rx;
    logic                  wr_en, msg_start, flag, enable;
    logic [IW-1:0]         wr_idx;
    logic [7:0]            wr_data, off, rd_mux;
    logic [DEPTH-1:0][7:0] slots;
    logic                  stat_rd, en_wr;

    assign rx      = '{valid: rx_valid, data: rx_byte};
    assign stat_rd = rd_en && rd_addr == STAT_ADDR;
    assign en_wr   = cfg_wr && cfg_addr == ENAB_ADDR;

    trail_id_seq #(.DEPTH(DEPTH)) u_seq (
        .clk(clk), .rst(rst), .rx(rx),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data), .msg_start(msg_start)
    );

    trail_id_store #(.DEPTH(DEPTH)) u_store (
        .clk(clk), .rst(rst),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data), .slots(slots)
    );

    trail_id_status u_status (
        .clk(clk), .rst(rst),
        .set_evt(msg_start), .clr_evt(stat_rd),
        .en_wr(en_wr), .en_val(cfg_data[FLAG_BIT]),
        .flag(flag), .enable(enable), .irq(irq)
    );

    assign off = rd_addr - SLOT_BASE;

    always_comb begin
        rd_mux = 8'h00;
        if (rd_addr == STAT_ADDR) begin
            rd_mux = flag_to_reg(flag);
        end else if (rd_addr == ENAB_ADDR) begin
            rd_mux = flag_to_reg(enable);
        end else if (off < 8'(DEPTH)) begin
            rd_mux = slots[off[IW-1:0]];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data <= 8'h00;
        end else if (rd_en) begin
            rd_data <= rd_mux;
        end
    end

    p_slot0_marker_r2: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && rx_byte[7]) |=> slots[0] == $past(rx_byte));
    p_stat_spare_zero_r6: assert property (@(posedge clk) disable iff (rst)
        $past(stat_rd) |-> (rd_data & 8'hBF) == 8'h00);
endmodule

// File: tb/trail_id_capture_test.sv
`timescale 1ns/1ps
module trail_id_capture_test;
    logic       clk = 1'b0;
    logic       rst;
    logic       rx_valid, rd_en, cfg_wr;
    logic [7:0] rx_byte, rd_addr, cfg_addr, cfg_data, rd_data;
    logic       irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [7:0] m_slot [16];
    int         m_ptr;
    bit         m_flag, m_en;

    always #2.5 clk = ~clk;

    trail_id_capture uut (
        .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_byte(rx_byte),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
        .cfg_wr(cfg_wr), .cfg_addr(cfg_addr), .cfg_data(cfg_data), .irq(irq)
    );

    function automatic logic [7:0] exp_read(input logic [7:0] a);
        if (a == 8'h15) return {1'b0, m_flag, 6'b0};
        if (a == 8'h11) return {1'b0, m_en, 6'b0};
        if (a >= 8'h1C && a <= 8'h2B) return m_slot[a - 8'h1C];
        return 8'h00;
    endfunction

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    // One clock: drive at negedge, update model, check at next negedge.
    task automatic step(input bit v, input logic [7:0] b, input bit rd,
                        input logic [7:0] ra, input bit wr, input logic [7:0] wa,
                        input logic [7:0] wd, input string req);
        logic [7:0] exp_rd;
        rx_valid = v; rx_byte = b; rd_en = rd; rd_addr = ra;
        cfg_wr = wr; cfg_addr = wa; cfg_data = wd;
        exp_rd = exp_read(ra);
        if (rd && ra == 8'h15) m_flag = 1'b0;
        if (v && b[7]) begin
            m_slot[0] = b; m_ptr = 1; m_flag = 1'b1;
        end else if (v && m_ptr < 16) begin
            m_slot[m_ptr] = b; m_ptr++;
        end
        if (wr && wa == 8'h11) m_en = wd[6];
        @(negedge clk);
        rx_valid = 1'b0; rd_en = 1'b0; cfg_wr = 1'b0;
        if (rd) check(req, rd_data, exp_rd);
        check("R9 irq", {7'b0, irq}, {7'b0, m_flag & m_en});
    endtask

    task automatic put(input logic [7:0] b);
        step(1'b1, b, 1'b0, 8'h00, 1'b0, 8'h00, 8'h00, "R3");
    endtask

    task automatic rd(input logic [7:0] a, input string req);
        step(1'b0, 8'h00, 1'b1, a, 1'b0, 8'h00, 8'h00, req);
    endtask

    task automatic model_reset();
        foreach (m_slot[i]) m_slot[i] = 8'h00;
        m_ptr = 16; m_flag = 1'b0; m_en = 1'b0;
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd7741));
        rst = 1'b1; rx_valid = 0; rx_byte = 0; rd_en = 0; rd_addr = 0;
        cfg_wr = 0; cfg_addr = 0; cfg_data = 0;
        model_reset();
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        for (int a = 8'h1C; a <= 8'h2B; a++) rd(8'(a), "R1 slot");
        rd(8'h15, "R1 status");
        rd(8'h11, "R1 enable");
        check("R1 irq", {7'b0, irq}, 8'h00);

        // R4 bytes before any marker discarded
        put(8'h41); put(8'h42);
        rd(8'h1C, "R4 unarmed"); rd(8'h1D, "R4 unarmed");

        // R9 enable, R2/R3 full message, R10 marker bits kept
        step(0, 0, 0, 0, 1'b1, 8'h11, 8'h40, "R9");
        rd(8'h11, "R9 enable readback");
        put(8'hFF);
        for (int i = 1; i < 16; i++) put(8'(8'h40 + i));
        for (int a = 8'h1C; a <= 8'h2B; a++) rd(8'(a), "R3 slot order");
        rd(8'h1C, "R10 marker kept");

        // R4 overflow discarded
        put(8'h21); put(8'h22);
        rd(8'h2B, "R4 after full"); rd(8'h1D, "R4 after full");

        // R7 clear on read
        rd(8'h15, "R7 first read");
        rd(8'h15, "R7 cleared");

        // R2 marker mid-message, gaps (R3)
        put(8'h80); put(8'h31);
        step(0, 8'h55, 0, 0, 0, 0, 0, "R3 idle");
        put(8'h32); put(8'h9A);
        rd(8'h1C, "R2 restart"); rd(8'h1D, "R2 slot1 kept");
        rd(8'h1E, "R3 gap"); 

        // R8 set wins
        rd(8'h15, "R7 clear");
        step(1'b1, 8'hC3, 1'b1, 8'h15, 0, 0, 0, "R8 old value");
        rd(8'h15, "R8 flag kept");

        // R5 unmapped and R6 spare bits
        rd(8'h00, "R5 unmapped"); rd(8'h2C, "R5 unmapped"); rd(8'h1B, "R5 unmapped");
        rd(8'hFF, "R5 unmapped");

        // Random phase
        for (int n = 0; n < 4000; n++) begin
            bit v, r, w;
            logic [7:0] b, a, wd;
            v = ($urandom % 3) != 0;
            b = 8'($urandom % 128);
            if ($urandom % 12 == 0) b[7] = 1'b1;
            r = ($urandom % 2) == 0;
            a = ($urandom % 4 == 0) ? 8'h15 : 8'(8'h10 + $urandom % 32);
            w = ($urandom % 40) == 0;
            wd = 8'($urandom);
            step(v, b, r, a, w, 8'h11, wd, "R5 random read");
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule